// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

This block moves data on a 16-bit system bus on behalf of two independent channels. Each channel holds a control word, a source pointer, a destination pointer and a transfer counter. A channel is armed by loading all four together. While armed, it asks for service according to its synchronization mode: free-running, gated by its external request line, or gated by a pending tick from the system timer.

An arbiter picks one requesting channel. A DMA cycle takes the bus ahead of a waiting CPU access unless that access is a word access to an odd address or part of a locked sequence. Each transfer is a read from the source pointer into an internal 16-bit latch, followed by a write of the latch to the destination pointer. After the write, both pointers advance by the transfer size and the counter steps down by one. A channel can be told to disarm itself when the counter reaches zero, and to raise an interrupt pulse on that final transfer. An NMI aborts any DMA cycle at once and holds the engine off the bus while it stays asserted.

Top module: `dma2_engine`

## Requirements
- R1: A transfer is one read cycle (`bus_rd_o`, address = source pointer) followed directly by one write cycle (`bus_wr_o`, address = destination pointer), and the write data equals the data read. With a free-running channel, a new transfer starts in the cycle after the previous write, so each transfer takes three cycles.
- R2: Control bit 0 selects the size. 1 means word: both pointers advance by 2 and `bus_byte_o` is 0. 0 means byte: both pointers advance by 1 and `bus_byte_o` is 1.
- R3: The counter decrements after every completed write. When control bit 9 is 1, the channel disarms on the write that takes the counter from 1 to 0. When bit 9 is 0, the channel keeps transferring.
- R4: When control bit 8 is 1, the write that takes the counter from 1 to 0 produces a one-cycle pulse on that channel's `irq_o` bit, in the cycle after that write. When bit 8 is 0, no pulse is produced. At most one `irq_o` bit is high at a time.
- R5: Control bits 7:6 select the synchronization mode: 00 requests whenever armed; 01 (source side) and 10 (destination side) request only while the channel's `drq_i` bit is high or a timer tick is pending; 11 never requests. A `drq_i` pulse one cycle long, seen while the engine is idle, yields exactly one transfer.
- R6: When control bit 4 is 1, a `tmr2_tick_i` pulse sets a pending request for that channel. The pending request is cleared when the channel is granted, so one tick yields one transfer. When bit 4 is 0, ticks are ignored.
- R7: When both channels request, the channel whose control bit 5 is 1 while the other's is 0 wins. When the bit 5 values are equal, service alternates between the channels on each transfer.
- R8: A pending DMA request wins over `cpu_req_i` unless `cpu_odd_word_i` or `cpu_lock_i` is high; in those cases no DMA cycle starts. `cpu_gnt_o` is high only when the CPU requests and no DMA cycle runs or starts.
- R9: While `nmi_i` is high, no DMA read or write is driven and no transfer starts. A transfer aborted in its read cycle leaves the pointers and the counter unchanged.
- R10: A load strobe on a channel's `ld_i` bit replaces its control word, pointers and counter, clears its pending timer request, and arms it. A reload with mode 11 parks the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 2 | Per-channel load strobe |
| ld_ctl_i | input | 16 | Control word to load |
| ld_src_i | input | AW | Source pointer to load |
| ld_dst_i | input | AW | Destination pointer to load |
| ld_cnt_i | input | CW | Transfer count to load |
| drq_i | input | 2 | Per-channel external request |
| tmr2_tick_i | input | 1 | System timer expiry pulse |
| cpu_req_i | input | 1 | CPU wants the bus |
| cpu_odd_word_i | input | 1 | CPU access is a word at an odd address |
| cpu_lock_i | input | 1 | CPU access is inside a locked sequence |
| nmi_i | input | 1 | Non-maskable interrupt request |
| bus_rdata_i | input | 16 | Read data from the bus |
| bus_addr_o | output | AW | Bus address |
| bus_rd_o | output | 1 | DMA read strobe |
| bus_wr_o | output | 1 | DMA write strobe |
| bus_byte_o | output | 1 | Transfer is byte sized |
| bus_wdata_o | output | 16 | Write data (latched read data) |
| cpu_gnt_o | output | 1 | Bus granted to the CPU this cycle |
| dma_busy_o | output | 1 | Engine is in a read or write cycle |
| irq_o | output | 2 | Per-channel final-transfer interrupt pulse |

## Verification
The assertions assume that a load strobe does not coincide with the final write of the same channel, and that no channel is loaded with a count of zero. Under those conditions the terminal-count and interrupt checks stay well defined. The assertions also assume that `bus_rdata_i` is valid in the read cycle. The bench loads channels only while they are parked or while a locked CPU access holds the engine idle, always uses nonzero counts, and drives read data combinationally from the address. It drives request, tick and NMI pulses away from the clock edge, so each pulse is seen in a known idle or read cycle.

// File: rtl/dma2_pkg.sv
`timescale 1ns/1ps
package dma2_pkg;
  localparam int CH_N = 2;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_READ = 2'd1, SQ_WRITE = 2'd2} sq_state_e;
  typedef enum logic [1:0] {SY_FREE = 2'b00, SY_SRC = 2'b01, SY_DST = 2'b10, SY_OFF = 2'b11} sync_e;
  localparam int B_WORD = 0;
  localparam int B_TMR  = 4;
  localparam int B_PRI  = 5;
  localparam int B_SYLO = 6;
  localparam int B_IRQ  = 8;
  localparam int B_STOP = 9;
endpackage

// File: rtl/dma2_chan.sv
`timescale 1ns/1ps
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [15:0]   ctl_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          drq_i,
  input  logic          tick_i,
  input  logic          grant_i,
  input  logic          done_i,
  output logic          req_o,
  output logic          pri_o,
  output logic          word_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [15:0]   ctl_q, ctl_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d, step;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d, tpend_q, tpend_d, irq_q, irq_d;
  sync_e         mode;
  logic          unused_ctl;

  assign unused_ctl = ^{ctl_q[15:10], ctl_q[3:1]};
  assign mode  = sync_e'(ctl_q[B_SYLO+1:B_SYLO]);
  assign step  = {{(AW-2){1'b0}}, ctl_q[B_WORD], ~ctl_q[B_WORD]};

  always_comb begin
    ctl_d = ctl_q; src_d = src_q; dst_d = dst_q; cnt_d = cnt_q;
    armed_d = armed_q; tpend_d = tpend_q; irq_d = 1'b0;
    if (load_i) begin
      ctl_d = ctl_i; src_d = src_i; dst_d = dst_i; cnt_d = cnt_i;
      armed_d = 1'b1; tpend_d = 1'b0;
    end else begin
      if (tick_i && ctl_q[B_TMR]) tpend_d = 1'b1;
      if (grant_i) tpend_d = 1'b0;
      if (done_i) begin
        src_d = src_q + step;
        dst_d = dst_q + step;
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) begin
          irq_d = ctl_q[B_IRQ];
          if (ctl_q[B_STOP]) armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; src_q <= '0; dst_q <= '0; cnt_q <= '0;
      armed_q <= 1'b0; tpend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d; src_q <= src_d; dst_q <= dst_d; cnt_q <= cnt_d;
      armed_q <= armed_d; tpend_q <= tpend_d; irq_q <= irq_d;
    end
  end

  assign req_o  = armed_q && (mode != SY_OFF) && ((mode == SY_FREE) || drq_i || tpend_q);
  assign pri_o  = ctl_q[B_PRI];
  assign word_o = ctl_q[B_WORD];
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign irq_o  = irq_q;

  // R3: terminal count with stop enabled disarms the channel
  p_tc_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !load_i && ctl_q[B_STOP] && cnt_q == ONE) |=> !req_o);
  // R4: interrupt is a single-cycle pulse
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: rtl/dma2_arb.sv
`timescale 1ns/1ps
module dma2_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic [1:0] pri_i,
  input  logic       idle_i,
  input  logic       blocked_i,
  output logic       start_o,
  output logic       win_o
);
  logic last_q, last_d;

  always_comb begin
    if (req_i == 2'b11) begin
      if (pri_i[0] != pri_i[1]) win_o = pri_i[1];
      else                      win_o = ~last_q;
    end else begin
      win_o = req_i[1];
    end
    start_o = idle_i && (|req_i) && !blocked_i;
    last_d  = start_o ? win_o : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  // R7: a start always serves a channel that is requesting
  p_win_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> req_i[win_o]);
endmodule

// File: rtl/dma2_seq.sv
`timescale 1ns/1ps
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          win_i,
  input  logic          nmi_i,
  input  logic [AW-1:0] src_i [CH_N],
  input  logic [AW-1:0] dst_i [CH_N],
  input  logic [1:0]    word_i,
  input  logic [15:0]   rdata_i,
  output logic          idle_o,
  output logic [1:0]    grant_o,
  output logic [1:0]    done_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          byte_o,
  output logic [15:0]   wdata_o
);
  sq_state_e   st_q, st_d;
  logic        sel_q, sel_d;
  logic [15:0] lat_q, lat_d;

  always_comb begin
    st_d = st_q; sel_d = sel_q; lat_d = lat_q;
    case (st_q)
      SQ_IDLE:  if (start_i) begin st_d = SQ_READ; sel_d = win_i; end
      SQ_READ:  if (nmi_i) st_d = SQ_IDLE;
                else begin st_d = SQ_WRITE; lat_d = rdata_i; end
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE; sel_q <= 1'b0; lat_q <= '0;
    end else begin
      st_q <= st_d; sel_q <= sel_d; lat_q <= lat_d;
    end
  end

  assign idle_o  = (st_q == SQ_IDLE);
  assign rd_o    = (st_q == SQ_READ) && !nmi_i;
  assign wr_o    = (st_q == SQ_WRITE) && !nmi_i;
  assign addr_o  = (st_q == SQ_WRITE) ? dst_i[sel_q] : src_i[sel_q];
  assign byte_o  = !word_i[sel_q];
  assign wdata_o = lat_q;
  assign grant_o = start_i ? (win_i ? 2'b10 : 2'b01) : 2'b00;
  assign done_o  = wr_o ? (sel_q ? 2'b10 : 2'b01) : 2'b00;

  // R1: the write cycle always follows a read cycle
  p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WRITE) |-> $past(st_q == SQ_READ));
endmodule

// File: rtl/dma2_engine.sv
`timescale 1ns/1ps
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ld_i,
  input  logic [15:0]   ld_ctl_i,
  input  logic [AW-1:0] ld_src_i,
  input  logic [AW-1:0] ld_dst_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic [1:0]    drq_i,
  input  logic          tmr2_tick_i,
  input  logic          cpu_req_i,
  input  logic          cpu_odd_word_i,
  input  logic          cpu_lock_i,
  input  logic          nmi_i,
  input  logic [15:0]   bus_rdata_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic          bus_byte_o,
  output logic [15:0]   bus_wdata_o,
  output logic          cpu_gnt_o,
  output logic          dma_busy_o,
  output logic [1:0]    irq_o
);
  logic [AW-1:0] src_w [CH_N];
  logic [AW-1:0] dst_w [CH_N];
  logic [1:0]    req_w, pri_w, word_w, grant_w, done_w;
  logic          start_w, win_w, idle_w, blocked_w;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    dma2_chan #(.AW(AW), .CW(CW)) i_chan (
      .clk(clk), .rst_n(rst_n), .load_i(ld_i[c]), .ctl_i(ld_ctl_i),
      .src_i(ld_src_i), .dst_i(ld_dst_i), .cnt_i(ld_cnt_i),
      .drq_i(drq_i[c]), .tick_i(tmr2_tick_i), .grant_i(grant_w[c]),
      .done_i(done_w[c]), .req_o(req_w[c]), .pri_o(pri_w[c]),
      .word_o(word_w[c]), .src_o(src_w[c]), .dst_o(dst_w[c]), .irq_o(irq_o[c])
    );
  end

  assign blocked_w = nmi_i || (cpu_req_i && (cpu_odd_word_i || cpu_lock_i));

  dma2_arb i_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .pri_i(pri_w), .idle_i(idle_w),
    .blocked_i(blocked_w), .start_o(start_w), .win_o(win_w)
  );

  dma2_seq #(.AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .win_i(win_w), .nmi_i(nmi_i),
    .src_i(src_w), .dst_i(dst_w), .word_i(word_w), .rdata_i(bus_rdata_i),
    .idle_o(idle_w), .grant_o(grant_w), .done_o(done_w), .addr_o(bus_addr_o),
    .rd_o(bus_rd_o), .wr_o(bus_wr_o), .byte_o(bus_byte_o), .wdata_o(bus_wdata_o)
  );

  assign cpu_gnt_o  = cpu_req_i && idle_w && !start_w;
  assign dma_busy_o = !idle_w;

  // R8: a locked CPU access keeps DMA off the bus
  p_lock_yield_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && cpu_lock_i && idle_w) |=> !bus_rd_o);
  // R8: CPU grant and DMA strobes never overlap
  p_gnt_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt_o && (bus_rd_o || bus_wr_o)));
  // R9: NMI leaves no write in the following cycle
  p_nmi_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> !bus_wr_o);
  // R4: at most one channel interrupt at a time
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
endmodule

// File: tb/test_dma2_engine.sv
`timescale 1ns/1ps
module test_dma2_engine;
  localparam int AW = 20;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ld;
  logic [15:0] ld_ctl;
  logic [AW-1:0] ld_src, ld_dst;
  logic [CW-1:0] ld_cnt;
  logic [1:0] drq;
  logic tick, cpu_req, cpu_odd, cpu_lock, nmi;
  logic [15:0] rdata, wdata;
  logic [AW-1:0] addr;
  logic rd, wr, byt, gnt, busy;
  logic [1:0] irq;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction
  assign rdata = memf(addr);

  dma2_engine #(.AW(AW), .CW(CW)) i_dma2_engine (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_ctl_i(ld_ctl), .ld_src_i(ld_src),
    .ld_dst_i(ld_dst), .ld_cnt_i(ld_cnt), .drq_i(drq), .tmr2_tick_i(tick),
    .cpu_req_i(cpu_req), .cpu_odd_word_i(cpu_odd), .cpu_lock_i(cpu_lock),
    .nmi_i(nmi), .bus_rdata_i(rdata), .bus_addr_o(addr), .bus_rd_o(rd),
    .bus_wr_o(wr), .bus_byte_o(byt), .bus_wdata_o(wdata), .cpu_gnt_o(gnt),
    .dma_busy_o(busy), .irq_o(irq)
  );

  int checks = 0, fails = 0, n_wr = 0, cyc = 0, overlap = 0;
  int irq_n [2];
  int irq_cyc, last_wr_cyc;
  logic [AW-1:0] wr_addr [64];
  logic [15:0]   wr_data [64];
  logic          wr_byte [64];
  bit done_flag = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr && n_wr < 64) begin
      wr_addr[n_wr] = addr; wr_data[n_wr] = wdata; wr_byte[n_wr] = byt;
      n_wr = n_wr + 1; last_wr_cyc = cyc;
    end
    for (int c = 0; c < 2; c++) if (irq[c]) begin irq_n[c] = irq_n[c] + 1; irq_cyc = cyc; end
    if (gnt && (rd || wr)) overlap = overlap + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit stop, input bit ie, input logic [1:0] sy,
                                     input bit pri, input bit tmr, input bit word);
    logic [15:0] v = '0;
    v[9] = stop; v[8] = ie; v[7:6] = sy; v[5] = pri; v[4] = tmr; v[0] = word;
    return v;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [1:0] m, input logic [15:0] c, input logic [AW-1:0] s,
                      input logic [AW-1:0] d, input logic [CW-1:0] n);
    @(posedge clk); #1;
    ld = m; ld_ctl = c; ld_src = s; ld_dst = d; ld_cnt = n;
    @(posedge clk); #1;
    ld = 2'b00;
  endtask

  task automatic clear_log();
    n_wr = 0; irq_n[0] = 0; irq_n[1] = 0;
  endtask

  task automatic park();
    load(2'b11, mk(0, 0, 2'b11, 0, 0, 0), '0, '0, 16'd1);
    waitc(4);
    clear_log();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd && !wr && !busy, "R1 reset strobes", {rd, wr, busy}, 0);
    chk(irq == 2'b00 && !gnt, "R4 reset irq", {irq, gnt}, 0);
  endtask

  task automatic t_word();
    park();
    load(2'b01, mk(1, 1, 2'b00, 0, 0, 1), 20'h00100, 20'h01000, 16'd3);
    waitc(20);
    chk(n_wr == 3, "R3 word count stop", n_wr, 3);
    for (int k = 0; k < 3; k++) begin
      chk(wr_addr[k] == 20'h01000 + 2 * k, "R2 word dst step", wr_addr[k], 20'h01000 + 2 * k);
      chk(wr_data[k] == memf(20'h00100 + 2 * k), "R1 read data moved", wr_data[k], memf(20'h00100 + 2 * k));
      chk(wr_byte[k] == 1'b0, "R2 word size flag", wr_byte[k], 0);
    end
    chk(irq_n[0] == 1, "R4 irq once", irq_n[0], 1);
    chk(irq_cyc == last_wr_cyc + 1, "R4 irq timing", irq_cyc, last_wr_cyc + 1);
  endtask

  task automatic t_byte();
    park();
    load(2'b10, mk(1, 0, 2'b00, 0, 0, 0), 20'h00301, 20'h02001, 16'd2);
    waitc(15);
    chk(n_wr == 2, "R3 byte count", n_wr, 2);
    chk(wr_addr[1] == 20'h02002, "R2 byte dst step", wr_addr[1], 20'h02002);
    chk(wr_data[1] == memf(20'h00302), "R2 byte src step", wr_data[1], memf(20'h00302));
    chk(wr_byte[0] == 1'b1, "R2 byte size flag", wr_byte[0], 1);
    chk(irq_n[1] == 0, "R4 irq disabled", irq_n[1], 0);
  endtask

  task automatic t_nostop();
    park();
    load(2'b01, mk(0, 0, 2'b00, 0, 0, 1), 20'h00200, 20'h01200, 16'd2);
    waitc(20);
    chk(n_wr > 2, "R3 no stop continues", n_wr, 3);
    load(2'b01, mk(0, 0, 2'b11, 0, 0, 1), 20'h00200, 20'h01200, 16'd2);
    waitc(4);
    clear_log();
    waitc(20);
    chk(n_wr == 0, "R5 mode 11 no transfer", n_wr, 0);
    chk(n_wr == 0, "R10 reload parks", n_wr, 0);
  endtask

  task automatic t_sync();
    park();
    load(2'b01, mk(1, 0, 2'b01, 0, 0, 1), 20'h00400, 20'h01400, 16'd5);
    waitc(15);
    chk(n_wr == 0, "R5 src sync waits", n_wr, 0);
    drq = 2'b01; waitc(1); drq = 2'b00;
    waitc(10);
    chk(n_wr == 1, "R5 src sync one pulse", n_wr, 1);
    park();
    load(2'b10, mk(1, 0, 2'b10, 0, 0, 1), 20'h00500, 20'h02500, 16'd5);
    waitc(10);
    chk(n_wr == 0, "R5 dst sync waits", n_wr, 0);
    drq = 2'b10; waitc(1); drq = 2'b00;
    waitc(10);
    chk(n_wr == 1 && wr_addr[0] == 20'h02500, "R5 dst sync one pulse", n_wr, 1);
  endtask

  task automatic t_timer();
    park();
    load(2'b10, mk(1, 0, 2'b01, 0, 1, 1), 20'h00600, 20'h02600, 16'd5);
    load(2'b01, mk(1, 0, 2'b01, 0, 0, 1), 20'h00700, 20'h01700, 16'd5);
    waitc(8);
    tick = 1'b1; waitc(1); tick = 1'b0;
    waitc(12);
    chk(n_wr == 1, "R6 one tick one transfer", n_wr, 1);
    chk(wr_addr[0] == 20'h02600, "R6 tick ignored when bit clear", wr_addr[0], 20'h02600);
  endtask

  task automatic t_prio();
    park();
    cpu_req = 1'b1; cpu_lock = 1'b1;
    load(2'b01, mk(1, 0, 2'b00, 0, 0, 1), 20'h00800, 20'h01800, 16'd2);
    load(2'b10, mk(1, 0, 2'b00, 1, 0, 1), 20'h00900, 20'h02900, 16'd2);
    cpu_lock = 1'b0; cpu_req = 1'b0;
    waitc(20);
    chk(n_wr == 4, "R7 prio count", n_wr, 4);
    chk(wr_addr[0][13:12] == 2'd2 && wr_addr[1][13:12] == 2'd2, "R7 high prio first",
        wr_addr[1], 20'h02902);
    chk(wr_addr[2][13:12] == 2'd1, "R7 low prio after", wr_addr[2], 20'h01800);
    park();
    cpu_req = 1'b1; cpu_lock = 1'b1;
    load(2'b01, mk(1, 0, 2'b00, 1, 0, 1), 20'h00800, 20'h01800, 16'd3);
    load(2'b10, mk(1, 0, 2'b00, 1, 0, 1), 20'h00900, 20'h02900, 16'd3);
    cpu_lock = 1'b0; cpu_req = 1'b0;
    waitc(25);
    chk(n_wr == 6, "R7 rr count", n_wr, 6);
    for (int k = 0; k < 5; k++)
      chk(wr_addr[k][13:12] != wr_addr[k+1][13:12], "R7 round robin alternates",
          wr_addr[k+1], wr_addr[k]);
  endtask

  task automatic t_cpu();
    park();
    cpu_req = 1'b1; cpu_lock = 1'b1;
    load(2'b01, mk(1, 0, 2'b00, 0, 0, 1), 20'h00A00, 20'h01A00, 16'd1);
    waitc(8);
    @(negedge clk);
    chk(n_wr == 0 && gnt, "R8 lock holds DMA off", n_wr, 0);
    cpu_lock = 1'b0;
    waitc(10);
    chk(n_wr == 1, "R8 DMA beats plain CPU", n_wr, 1);
    park();
    cpu_req = 1'b1; cpu_odd = 1'b1;
    load(2'b01, mk(1, 0, 2'b00, 0, 0, 1), 20'h00B00, 20'h01B00, 16'd1);
    waitc(8);
    chk(n_wr == 0, "R8 odd word holds DMA off", n_wr, 0);
    cpu_odd = 1'b0;
    waitc(10);
    chk(n_wr == 1, "R8 release odd word", n_wr, 1);
    cpu_req = 1'b0;
    chk(overlap == 0, "R8 grant exclusive", overlap, 0);
  endtask

  task automatic t_nmi();
    park();
    nmi = 1'b1;
    load(2'b01, mk(1, 0, 2'b00, 0, 0, 1), 20'h00C00, 20'h01C00, 16'd2);
    waitc(10);
    chk(n_wr == 0, "R9 NMI blocks start", n_wr, 0);
    nmi = 1'b0;
    for (int k = 0; k < 10 && !rd; k++) @(negedge clk);
    nmi = 1'b1;
    waitc(3);
    chk(n_wr == 0, "R9 NMI aborts read", n_wr, 0);
    nmi = 1'b0;
    waitc(15);
    chk(n_wr == 2, "R9 count kept after abort", n_wr, 2);
    chk(wr_addr[0] == 20'h01C00, "R9 pointer kept after abort", wr_addr[0], 20'h01C00);
  endtask

  initial begin
    rst_n = 1'b0; ld = '0; ld_ctl = '0; ld_src = '0; ld_dst = '0; ld_cnt = '0;
    drq = '0; tick = 0; cpu_req = 0; cpu_odd = 0; cpu_lock = 0; nmi = 0;
    irq_n[0] = 0; irq_n[1] = 0; irq_cyc = 0; last_wr_cyc = 0;
    waitc(3);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_byte();
    t_nostop();
    t_sync();
    t_timer();
    t_prio();
    t_cpu();
    t_nmi();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule